// File: doc/BRIEF.md
# Four-Group Carry Lookahead Unit

This block is a purely combinational lookahead stage for an adder split into four groups (single slices or clusters of slices). It takes one carry input in true form and, for each of the four groups, a propagate and a generate signal that arrive active-low, the form the adder slices produce. From these it computes the carries into groups 1, 2 and 3 in two levels of logic. It does not ripple through the groups.

It also returns a propagate and a generate for the whole four-group block, both active-low. These have the same form as its own group inputs, so four units can feed a fifth unit of the same design to build a 16-group lookahead tree, and further levels can be stacked in the same way. No carry out of group 3 is produced. The next level forms that carry from the block propagate and generate.

Top module: `cla4_unit`

## Requirements
- R1: Group inputs are active-low: `grp_prop_n[i]=0` means group i propagates and `grp_gen_n[i]=0` means group i generates. `carry_in` and `carry_out` are active-high. With every group input high and `carry_in=0`, all carries are 0 and both block outputs are 1.
- R2: `carry_out[0]` (the carry into group 1) is g0 | (p0 & cin), with p and g in true sense.
- R3: `carry_out[1]` (the carry into group 2) is g1 | p1 g0 | p1 p0 cin.
- R4: `carry_out[2]` (the carry into group 3) is g2 | p2 g1 | p2 p1 g0 | p2 p1 p0 cin.
- R5: `blk_gen_n` is low exactly when g3 | p3 g2 | p3 p2 g1 | p3 p2 p1 g0 is true.
- R6: `blk_prop_n` is low only when all four `grp_prop_n` bits are low.
- R7: `carry_in` has no effect on `blk_prop_n` or `blk_gen_n`.
- R8: Four units feeding a fifth unit give the same 16 group carries, and the same carry out of the whole tree, as a 16-group ripple chain.
- R9: All 512 combinations of `carry_in`, `grp_prop_n` and `grp_gen_n` match a ripple-style reference on all five outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| carry_in | input | 1 | Carry into group 0, active-high |
| grp_prop_n | input | 4 | Per-group propagate, active-low |
| grp_gen_n | input | 4 | Per-group generate, active-low |
| carry_out | output | 3 | Carries into groups 1..3, active-high (bit 0 = into group 1) |
| blk_prop_n | output | 1 | Block propagate, active-low |
| blk_gen_n | output | 1 | Block generate, active-low |

## Verification
Two sources can assert the same carry at once: a group's own generate and a carry propagated from `carry_in`. The exhaustive sweep covers every case where both are active together and every case where only one is. The result is judged against a ripple chain, which gives the same answer whichever source is active. A second collision is `carry_in` changing while a block generate is active. The isolation task toggles `carry_in` under each of the 256 group patterns and requires the block outputs to stay the same.

// File: rtl/cla_pkg.sv
// Shared types for the carry lookahead unit.
// Assumes all signals inside the package are in true (active-high) sense.
package cla_pkg;

    typedef struct packed {
        logic p;
        logic g;
    } pg_t;

    // Merge a more significant span (hi) with a less significant span (lo).
    function automatic pg_t pg_combine(input pg_t hi, input pg_t lo);
        pg_t r;
        r.p = hi.p & lo.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction

endpackage

// File: rtl/cla_pol_in.sv
// Converts the active-low group propagate/generate inputs to true-sense pairs.
// Assumes: inputs are driven by slices that present P and G active-low.
module cla_pol_in #(
    parameter int GROUPS = 4
) (
    input  logic [GROUPS-1:0]          prop_n,
    input  logic [GROUPS-1:0]          gen_n,
    output cla_pkg::pg_t [GROUPS-1:0]  pg
);
    // One inverter pair per group.
    for (genvar i = 0; i < GROUPS; i++) begin : g_inv
        assign pg[i].p = ~prop_n[i];
        assign pg[i].g = ~gen_n[i];
    end
endmodule

// File: rtl/cla_carry_sop.sv
// Flat sum-of-products carries into groups 1..GROUPS-1 (no rippling).
// Assumes: true-sense pg inputs; carry k is the carry out of group k.
module cla_carry_sop #(
    parameter int GROUPS = 4,
    localparam int NCARRY = GROUPS - 1
) (
    input  cla_pkg::pg_t [GROUPS-1:0] pg,
    input  logic                      cin,
    output logic [NCARRY-1:0]         carries
);
    // Each carry: OR over sources j<=k of g[j] masked by p[j+1..k], plus cin masked by p[0..k].
    always_comb begin
        for (int k = 0; k < NCARRY; k++) begin
            logic acc;
            logic cin_term;
            cin_term = cin;
            for (int m = 0; m < GROUPS; m++) begin
                if (m <= k) cin_term = cin_term & pg[m].p;
            end
            acc = cin_term;
            for (int j = 0; j < GROUPS; j++) begin
                logic term;
                term = pg[j].g;
                for (int m = 0; m < GROUPS; m++) begin
                    if (m > j && m <= k) term = term & pg[m].p;
                end
                if (j <= k) acc = acc | term;
            end
            carries[k] = acc;
        end
    end

    // Guard: a carry plus the next group's propagate must give the next carry (R3, R4).
    always_comb begin
        for (int k = 0; k + 1 < NCARRY; k++) begin
            a_r3_r4_chain: assert (!(carries[k] && pg[k+1].p) || carries[k+1]);
        end
    end
endmodule

// File: rtl/cla_block_pg.sv
// Block-level propagate/generate by folding group pairs from LSB upward; outputs active-low.
// Assumes: true-sense pg inputs; carry input deliberately absent.
module cla_block_pg #(
    parameter int GROUPS = 4
) (
    input  cla_pkg::pg_t [GROUPS-1:0] pg,
    output logic                      blk_prop_n,
    output logic                      blk_gen_n
);
    import cla_pkg::*;

    pg_t [GROUPS-1:0] span;

    // Prefix fold: span[i] covers groups 0..i.
    assign span[0] = pg[0];
    for (genvar i = 1; i < GROUPS; i++) begin : g_fold
        assign span[i] = pg_combine(pg[i], span[i-1]);
    end

    assign blk_prop_n = ~span[GROUPS-1].p;
    assign blk_gen_n  = ~span[GROUPS-1].g;

    // Guard: low block propagate needs every group propagating; top generate forces block generate (R6, R5).
    always_comb begin
        logic all_p;
        all_p = 1'b1;
        for (int i = 0; i < GROUPS; i++) all_p = all_p & pg[i].p;
        a_r6_prop_needs_all: assert (blk_prop_n || all_p);
        a_r5_top_gen: assert (!pg[GROUPS-1].g || !blk_gen_n);
    end
endmodule

// File: rtl/cla4_unit.sv
// Four-group carry lookahead unit: true-sense carries in/out, active-low group and block P/G.
// Assumes: purely combinational use; no clock or reset; block outputs feed a same-design unit above.
module cla4_unit #(
    parameter int GROUPS = 4,
    localparam int NCARRY = GROUPS - 1
) (
    input  logic              carry_in,
    input  logic [GROUPS-1:0] grp_prop_n,
    input  logic [GROUPS-1:0] grp_gen_n,
    output logic [NCARRY-1:0] carry_out,
    output logic              blk_prop_n,
    output logic              blk_gen_n
);
    cla_pkg::pg_t [GROUPS-1:0] pg;

    cla_pol_in #(.GROUPS(GROUPS)) u_pol (
        .prop_n (grp_prop_n),
        .gen_n  (grp_gen_n),
        .pg     (pg)
    );

    cla_carry_sop #(.GROUPS(GROUPS)) u_carry (
        .pg      (pg),
        .cin     (carry_in),
        .carries (carry_out)
    );

    cla_block_pg #(.GROUPS(GROUPS)) u_blk (
        .pg         (pg),
        .blk_prop_n (blk_prop_n),
        .blk_gen_n  (blk_gen_n)
    );

    // Cross-check carry logic against block logic and port polarity (R1, R2).
    always_comb begin
        a_r1_full_prop: assert (blk_prop_n || !carry_in || (&carry_out));
        a_r2_gen0: assert (grp_gen_n[0] || carry_out[0]);
        a_r1_idle: assert (!((&grp_prop_n) && (&grp_gen_n)) || (carry_out == '0 && blk_gen_n));
    end
endmodule

// File: tb/tb_cla4_unit.sv
module tb_cla4_unit;
    localparam int GROUPS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic       carry_in;
    logic [3:0] grp_prop_n, grp_gen_n;
    logic [2:0] carry_out;
    logic       blk_prop_n, blk_gen_n;

    cla4_unit #(.GROUPS(GROUPS)) dut (
        .carry_in(carry_in), .grp_prop_n(grp_prop_n), .grp_gen_n(grp_gen_n),
        .carry_out(carry_out), .blk_prop_n(blk_prop_n), .blk_gen_n(blk_gen_n)
    );

    // Two-level tree for R8: four leaves feed one root.
    logic        t_c0;
    logic [15:0] t_prop_n, t_gen_n;
    logic [3:0]  leaf_cin, leaf_bp, leaf_bg;
    logic [2:0]  leaf_co [4];
    logic [2:0]  root_co;
    logic        root_bp, root_bg;

    assign leaf_cin = {root_co, t_c0};
    for (genvar u = 0; u < 4; u++) begin : g_leaf
        cla4_unit #(.GROUPS(4)) u_leaf (
            .carry_in(leaf_cin[u]), .grp_prop_n(t_prop_n[4*u +: 4]),
            .grp_gen_n(t_gen_n[4*u +: 4]), .carry_out(leaf_co[u]),
            .blk_prop_n(leaf_bp[u]), .blk_gen_n(leaf_bg[u])
        );
    end
    cla4_unit #(.GROUPS(4)) u_root (
        .carry_in(t_c0), .grp_prop_n(leaf_bp), .grp_gen_n(leaf_bg),
        .carry_out(root_co), .blk_prop_n(root_bp), .blk_gen_n(root_bg)
    );

    // Ripple reference: c[i+1] = g[i] | p[i] & c[i], true sense from active-low inputs.
    function automatic logic [16:0] ripple(input int n, input logic cin,
                                           input logic [15:0] pn, input logic [15:0] gn);
        logic [16:0] c;
        c = '0;
        c[0] = cin;
        for (int i = 0; i < 16; i++)
            if (i < n) c[i+1] = ~gn[i] | (~pn[i] & c[i]);
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cin=%b pn=%b gn=%b)",
                     req, act, exp, carry_in, grp_prop_n, grp_gen_n);
        end
    endtask

    task automatic apply(input logic cin, input logic [3:0] pn, input logic [3:0] gn);
        @(posedge clk); #1;
        carry_in = cin; grp_prop_n = pn; grp_gen_n = gn;
        @(negedge clk);
    endtask

    // R1: idle inputs give inactive outputs.
    task automatic t_idle();
        apply(1'b0, 4'hF, 4'hF);
        check("R1 carries", {29'd0, carry_out}, 32'd0);
        check("R1 blk_prop_n", {31'd0, blk_prop_n}, 32'd1);
        check("R1 blk_gen_n", {31'd0, blk_gen_n}, 32'd1);
    endtask

    // R2..R6, R9: all 512 input combinations against ripple reference.
    task automatic t_exhaustive();
        for (int v = 0; v < 512; v++) begin
            logic [16:0] c;
            logic [3:0]  pn, gn;
            logic        ci;
            ci = v[8]; pn = v[7:4]; gn = v[3:0];
            apply(ci, pn, gn);
            c = ripple(4, ci, {12'hFFF, pn}, {12'hFFF, gn});
            check("R2 carry1", {31'd0, carry_out[0]}, {31'd0, c[1]});
            check("R3 carry2", {31'd0, carry_out[1]}, {31'd0, c[2]});
            check("R4 carry3", {31'd0, carry_out[2]}, {31'd0, c[3]});
            check("R5 blk_gen_n", {31'd0, blk_gen_n},
                  {31'd0, ~ripple(4, 1'b0, {12'hFFF, pn}, {12'hFFF, gn})[4]});
            check("R6 blk_prop_n", {31'd0, blk_prop_n}, {31'd0, |pn});
            check("R9 all", {27'd0, carry_out, blk_prop_n, blk_gen_n},
                  {27'd0, c[3:1], |pn, ~ripple(4, 1'b0, {12'hFFF, pn}, {12'hFFF, gn})[4]});
        end
    endtask

    // R7: toggling carry_in leaves block outputs unchanged.
    task automatic t_cin_isolation();
        for (int v = 0; v < 256; v++) begin
            logic bp0, bg0;
            apply(1'b0, v[7:4], v[3:0]);
            bp0 = blk_prop_n; bg0 = blk_gen_n;
            apply(1'b1, v[7:4], v[3:0]);
            check("R7 block outputs vs cin", {30'd0, blk_prop_n, blk_gen_n}, {30'd0, bp0, bg0});
        end
    endtask

    // R8: 16-group tree against a 16-group ripple chain.
    task automatic t_cascade();
        for (int k = 0; k < 300; k++) begin
            logic [16:0] c, got;
            @(posedge clk); #1;
            t_c0 = 1'($urandom);
            t_prop_n = 16'($urandom);
            t_gen_n  = 16'($urandom) | 16'($urandom);
            if (k == 0) begin t_prop_n = '0; t_gen_n = '1; t_c0 = 1'b1; end
            if (k == 1) begin t_prop_n = '0; t_gen_n = 16'hFFFE; t_c0 = 1'b0; end
            @(negedge clk);
            c = ripple(16, t_c0, t_prop_n, t_gen_n);
            got[0] = t_c0;
            for (int u = 0; u < 4; u++) begin
                got[4*u]     = leaf_cin[u];
                got[4*u + 1] = leaf_co[u][0];
                got[4*u + 2] = leaf_co[u][1];
                got[4*u + 3] = leaf_co[u][2];
            end
            got[16] = ~root_bg | (~root_bp & t_c0);
            n_checks++;
            if (got !== c) begin
                n_fail++;
                $display("FAIL R8 tree carries actual=%h expected=%h", got, c);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        carry_in = 1'b0; grp_prop_n = 4'hF; grp_gen_n = 4'hF;
        t_c0 = 1'b0; t_prop_n = '1; t_gen_n = '1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_exhaustive();
        t_cin_isolation();
        t_cascade();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule